// File: doc/BRIEF.md
# Byte-Serial Error Event FIFO

This block keeps a short queue of packet error events and lets a host drain it one byte at a time through a single register location. A capture strobe on the event side supplies, in parallel, the number of the port that saw the bad packet, seven error flags and the 48-bit source address of that packet. Each accepted event becomes one queued entry. The host sees it as an eight-byte record: a header byte, a flag byte, then six address bytes.

The read side is a small state machine with three named states. `ST_HDR` presents byte 0. `ST_FLAGS` presents byte 1. `ST_ADDR` presents bytes 2 to 7, and an address index selects among them.

The transitions are as follows:
- `HDR_TO_FLAGS`: a read in `ST_HDR` while the queue holds an entry.
- `HDR_HOLD`: a read in `ST_HDR` on an empty queue. The state stays put and the empty header is returned.
- `FLAGS_TO_ADDR`: any read in `ST_FLAGS`. The address index clears.
- `ADDR_STEP`: a read in `ST_ADDR` below the last address byte. The index increments.
- `ADDR_TO_HDR`: the read of byte 7. The entry is popped.

Accesses that are writes, and cycles without an access, leave the machine where it is. When the queue is full, new events are dropped, except in a cycle where byte 7 is being read. In that cycle the freed slot is reused at once.

Top module: `evq_byte_port`

## Requirements
- R1: After reset the queue is empty and `rd_data` presents 0x00, the empty header.
- R2: In `ST_HDR` with an entry queued, `rd_data` is {1'b1, 3'b000, port[3:0]}: bit 7 is the valid mark and bits 3..0 are the port number.
- R3: In `ST_FLAGS`, `rd_data` bit 7 is 0. Bits 6..0 carry the flags in this order: very-long event (6), rate error (5), runt (4), short (3), long (2), alignment (1), checksum (0). These are `evt_flags[6:0]` as captured.
- R4: Record bytes 2..7 present the source address with the lowest byte first. Byte k shows `evt_src[8*(k-2)+7 : 8*(k-2)]`.
- R5: The read of byte 7 pops the entry. The next access presents byte 0 of the next entry, in arrival order.
- R6: A read of byte 0 while the queue is empty returns 0x00. The following access is again byte 0.
- R7: The queue holds DEPTH entries (default 8). An event that arrives while the queue is full, and no pop happens in that cycle, is discarded.
- R8: A capture and a byte-7 pop in the same cycle both take effect, even when the queue is full.
- R9: Only a cycle with `acc_stb`=1 and `acc_we`=0 counts as a read. Writes and idle cycles neither advance the byte position nor pop.
- R10: An event captured at a clock edge is visible as byte 0 from the next cycle, when the queue was empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_stb | input | 1 | Capture strobe for one error event |
| evt_port | input | 4 | Port number of the event |
| evt_flags | input | 7 | Error flags, bit order as in R3 |
| evt_src | input | 48 | Source address of the offending packet |
| acc_stb | input | 1 | Host access to the record register this cycle |
| acc_we | input | 1 | Access is a write (ignored) |
| rd_data | output | 8 | Byte currently presented by the record register |

## Verification
The checker watches the following on every cycle:
- the header and flag byte framing in each state;
- that an empty read holds the machine in `ST_HDR`;
- that writes and idle cycles never move the state or pop;
- that every pop returns to `ST_HDR`;
- that a full queue stays full both without a pop and with a simultaneous capture and pop.

Other properties can only be shown by the bench's scenarios, because they depend on what was captured earlier:
- the arrival order of records;
- the exact address byte order;
- the drop of surplus events once DEPTH entries are held;
- the content accepted in a swap cycle.

// File: rtl/evq_pkg.sv
package evq_pkg;
    localparam int PORT_W    = 4;
    localparam int FLAG_W    = 7;
    localparam int SRC_BYTES = 6;
    localparam int SRC_W     = 8 * SRC_BYTES;
    localparam int IDX_W     = $clog2(SRC_BYTES);
    localparam int HDR_PAD   = 7 - PORT_W;

    typedef struct packed {
        logic [PORT_W-1:0] port;
        logic [FLAG_W-1:0] flags;
        logic [SRC_W-1:0]  src;
    } evq_entry_t;

    typedef enum logic [1:0] {
        ST_HDR   = 2'd0,
        ST_FLAGS = 2'd1,
        ST_ADDR  = 2'd2
    } evq_state_t;
endpackage

// File: rtl/evq_store.sv
module evq_store
    import evq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_req,
    input  evq_entry_t push_data,
    input  logic       pop,
    output evq_entry_t head,
    output logic       empty,
    output logic       full
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    evq_entry_t    mem [DEPTH];
    logic          push_ok;

    assign empty   = (wr_ptr == rd_ptr);
    assign full    = (wr_ptr[AW] != rd_ptr[AW]) &&
                     (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
    // a pop in the same cycle frees the slot being written
    assign push_ok = push_req && (!full || pop);
    assign head    = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + PW'(1);
            if (pop)     rd_ptr <= rd_ptr + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr[AW-1:0]] <= push_data;
    end
endmodule

// File: rtl/evq_read_fsm.sv
module evq_read_fsm
    import evq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_acc,
    input  logic             fifo_empty,
    output evq_state_t       state,
    output logic [IDX_W-1:0] addr_idx,
    output logic             pop
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SRC_BYTES - 1);

    evq_state_t       state_q, state_n;
    logic [IDX_W-1:0] idx_q, idx_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HDR;
            idx_q   <= '0;
        end else begin
            state_q <= state_n;
            idx_q   <= idx_n;
        end
    end

    // transitions
    always_comb begin
        state_n = state_q;
        idx_n   = idx_q;
        unique case (state_q)
            ST_HDR: begin
                if (rd_acc && !fifo_empty) state_n = ST_FLAGS;   // HDR_TO_FLAGS
            end
            ST_FLAGS: begin
                if (rd_acc) begin                                // FLAGS_TO_ADDR
                    state_n = ST_ADDR;
                    idx_n   = '0;
                end
            end
            ST_ADDR: begin
                if (rd_acc) begin
                    if (idx_q == LAST_IDX) begin                 // ADDR_TO_HDR
                        state_n = ST_HDR;
                        idx_n   = '0;
                    end else begin                               // ADDR_STEP
                        idx_n = idx_q + IDX_W'(1);
                    end
                end
            end
            default: begin
                state_n = ST_HDR;
                idx_n   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        state    = state_q;
        addr_idx = idx_q;
        pop      = (state_q == ST_ADDR) && rd_acc && (idx_q == LAST_IDX);
    end
endmodule

// File: rtl/evq_byte_mux.sv
module evq_byte_mux
    import evq_pkg::*;
(
    input  evq_state_t       state,
    input  logic [IDX_W-1:0] addr_idx,
    input  logic             fifo_empty,
    input  evq_entry_t       head,
    output logic [7:0]       byte_o
);
    logic [7:0] src_b [SRC_BYTES];

    for (genvar g = 0; g < SRC_BYTES; g++) begin : g_src
        assign src_b[g] = head.src[8*g +: 8];
    end

    always_comb begin
        unique case (state)
            ST_HDR:   byte_o = fifo_empty ? 8'h00
                                          : {1'b1, {HDR_PAD{1'b0}}, head.port};
            ST_FLAGS: byte_o = {1'b0, head.flags};
            ST_ADDR:  byte_o = src_b[addr_idx];
            default:  byte_o = 8'h00;
        endcase
    end
endmodule

// File: rtl/evq_byte_port.sv
module evq_byte_port
    import evq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_stb,
    input  logic [PORT_W-1:0] evt_port,
    input  logic [FLAG_W-1:0] evt_flags,
    input  logic [SRC_W-1:0]  evt_src,
    input  logic              acc_stb,
    input  logic              acc_we,
    output logic [7:0]        rd_data
);
    evq_entry_t       cap_entry;
    evq_entry_t       head;
    evq_state_t       state;
    logic [IDX_W-1:0] addr_idx;
    logic             fifo_empty;
    logic             fifo_full;
    logic             pop;
    logic             rd_acc;

    assign rd_acc          = acc_stb && !acc_we;
    assign cap_entry.port  = evt_port;
    assign cap_entry.flags = evt_flags;
    assign cap_entry.src   = evt_src;

    evq_store #(.DEPTH(DEPTH)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (evt_stb),
        .push_data (cap_entry),
        .pop       (pop),
        .head      (head),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    evq_read_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_acc     (rd_acc),
        .fifo_empty (fifo_empty),
        .state      (state),
        .addr_idx   (addr_idx),
        .pop        (pop)
    );

    evq_byte_mux mux_i (
        .state      (state),
        .addr_idx   (addr_idx),
        .fifo_empty (fifo_empty),
        .head       (head),
        .byte_o     (rd_data)
    );
endmodule

// File: rtl/evq_checker.sv
module evq_checker
    import evq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             evt_stb,
    input logic             acc_stb,
    input logic             acc_we,
    input logic [7:0]       rd_data,
    input evq_state_t       state,
    input logic [IDX_W-1:0] addr_idx,
    input logic             fifo_empty,
    input logic             fifo_full,
    input logic             pop
);
    a_r6_empty_hdr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HDR && fifo_empty) |-> rd_data == 8'h00);

    a_r2_hdr_marker: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HDR && !fifo_empty) |-> rd_data[7:4] == 4'b1000);

    a_r3_flags_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLAGS) |-> (rd_data[7] == 1'b0 && !fifo_empty));

    a_r6_empty_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HDR && fifo_empty && acc_stb && !acc_we) |=> state == ST_HDR);

    a_r9_write_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_stb || acc_we) |=> ($stable(state) && $stable(addr_idx)));

    a_r9_write_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_stb || acc_we) |-> !pop);

    a_r5_pop_to_hdr: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> state == ST_HDR);

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && !pop) |=> fifo_full);

    a_r8_swap_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && pop && evt_stb) |=> fifo_full);
endmodule

bind evq_byte_port evq_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_stb    (evt_stb),
    .acc_stb    (acc_stb),
    .acc_we     (acc_we),
    .rd_data    (rd_data),
    .state      (state),
    .addr_idx   (addr_idx),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .pop        (pop)
);

// File: tb/evq_byte_port_tb_top.sv
module evq_byte_port_tb_top;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_stb = 1'b0;
    logic [3:0]  evt_port = '0;
    logic [6:0]  evt_flags = '0;
    logic [47:0] evt_src = '0;
    logic        acc_stb = 1'b0;
    logic        acc_we = 1'b0;
    logic [7:0]  rd_data;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    // bench model: queue of {port, flags, src} and current byte position
    logic [58:0] mq [$];
    int          m_idx = 0;

    always #10 clk = ~clk;   // 50 MHz

    evq_byte_port #(.DEPTH(DEPTH)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_stb   (evt_stb),
        .evt_port  (evt_port),
        .evt_flags (evt_flags),
        .evt_src   (evt_src),
        .acc_stb   (acc_stb),
        .acc_we    (acc_we),
        .rd_data   (rd_data)
    );

    function automatic logic [7:0] exp_byte(int idx, bit emp, logic [58:0] e);
        if (idx == 0) return emp ? 8'h00 : {4'b1000, e[58:55]};   // R2 / R6
        if (idx == 1) return {1'b0, e[54:48]};                    // R3
        return e[8*(idx-2) +: 8];                                 // R4
    endfunction

    function automatic logic [58:0] rnd_entry();
        logic [63:0] r;
        r = {$urandom(), $urandom()};
        return r[58:0];
    endfunction

    task automatic check(logic [7:0] got, logic [7:0] exp, string req, string ctx);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s (%s): rd_data=%02h expected %02h", req, ctx, got, exp);
        end
    endtask

    task automatic step(bit ev, logic [58:0] e, bit acc, bit we, string ctx);
        bit       rd, emp, pop;
        int       cnt;
        string    req;
        logic [7:0] exp;
        @(negedge clk);
        evt_stb   = ev;
        evt_port  = e[58:55];
        evt_flags = e[54:48];
        evt_src   = e[47:0];
        acc_stb   = acc;
        acc_we    = we;
        #1;
        emp = (mq.size() == 0);
        exp = exp_byte(m_idx, emp, emp ? 59'd0 : mq[0]);
        req = (m_idx == 0) ? (emp ? "R6" : "R2") : (m_idx == 1) ? "R3" : "R4";
        check(rd_data, exp, req, ctx);
        @(posedge clk);
        rd  = acc && !we;
        pop = 0;
        cnt = mq.size();
        if (rd) begin
            if (m_idx == 0) begin
                if (!emp) m_idx = 1;
            end else if (m_idx == 7) begin
                m_idx = 0;
                pop   = 1;
            end else begin
                m_idx++;
            end
        end
        if (pop) void'(mq.pop_front());
        if (ev && (cnt < DEPTH || pop)) mq.push_back(e);
    endtask

    task automatic push(logic [58:0] e, string ctx);
        step(1, e, 0, 0, ctx);
    endtask

    task automatic rd(int n, string ctx);
        for (int i = 0; i < n; i++) step(0, '0, 1, 0, ctx);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(rd_data, 8'h00, "R1", "reset state");

        rd(2, "R6 empty reads stay on byte 0");

        push(rnd_entry(), "R10 capture");
        rd(8, "R10 R5 single record");
        rd(1, "R5 after pop queue empty");

        push(rnd_entry(), "R9 setup");
        rd(3, "R9 partial");
        for (int i = 0; i < 3; i++) step(0, '0, 1, 1, "R9 write ignored");
        for (int i = 0; i < 2; i++) step(0, '0, 0, 0, "R9 idle");
        rd(6, "R9 resume");

        for (int i = 0; i < DEPTH + 2; i++) push(rnd_entry(), "R7 overfill");
        rd(8 * DEPTH + 2, "R7 drain DEPTH records then empty");

        for (int i = 0; i < DEPTH; i++) push(rnd_entry(), "R8 fill");
        rd(7, "R8 partial");
        step(1, rnd_entry(), 1, 0, "R8 capture with pop when full");
        push(rnd_entry(), "R8 full again drops");
        rd(8 * DEPTH + 1, "R8 R5 drain in order");

        for (int i = 0; i < 4000; i++) begin
            step(($urandom() % 10) < 3, rnd_entry(), ($urandom() % 2) == 1,
                 ($urandom() % 5) == 0, "random mix");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule